// File: doc/BRIEF.md
# Tamper Zeroization Sequencer

This block guards secret state against physical tampering. It watches one active-high tamper line and filters it, so that brief noise spikes are thrown away while a sustained assertion is taken as a real attack. The line first crosses into the clock domain through a two-flop synchronizer. A counter then measures how many consecutive cycles the line has stayed high. A confirmed tamper starts a one-shot destruction sequence.

The sequence overwrites every word of the encryption key store with zero, then every word of the vector RAM, at one word per clock, through the write ports the block drives. When the last word is written, a sticky done flag rises. From the first key write, the block also raises a supply-cut request for a fixed number of cycles. An external switch uses this request to drop power to the memory supply briefly. Once started, the sequence runs to the end whatever the tamper line does, and only reset brings the block back to its armed state.

The filter has a lower threshold `REJECT_CYC` and an upper threshold `ACCEPT_CYC`. It trips at a single point strictly between them: TRIP = REJECT_CYC + (ACCEPT_CYC − REJECT_CYC)/2, using integer division. With the defaults (6 and 20), TRIP is 13.

Top module: `tamper_zeroize`

## Requirements
- R1: While reset is low and in the first cycle after it is released, every output is 0.
- R2: A tamper run lasting fewer than TRIP consecutive high samples never starts the sequence. TRIP is 13 with the defaults, so every run shorter than REJECT_CYC is rejected.
- R3: A run of TRIP or more high samples starts the sequence. If the tamper input is first sampled high at clock edge n, key_we_o is first high after edge n+TRIP+1, with key_addr_o equal to 0.
- R4: A single low sample restarts the high-run count, so two sub-TRIP runs separated by one low cycle do not trigger.
- R5: Key words are written at addresses 0 through KEY_WORDS−1, one per cycle in ascending order. Vector words 0 through VEC_WORDS−1 follow on the very next cycles, also ascending. key_we_o and vec_we_o are never high in the same cycle, and each word is written exactly once.
- R6: Whenever a write enable is high, its data bus carries all zeros.
- R7: supply_cut_o rises on the same edge as the first key write and stays high for exactly CUT_CYC cycles (12 by default). It then stays low.
- R8: wipe_done_o rises on the edge after the last vector write and holds until reset. While it is high, no write enable and no supply cut is asserted.
- R9: After the sequence starts, the tamper input has no effect. Dropping it does not stop the sequence, and holding it or pulsing it again during or after the sequence does not start a second pass.
- R10: Asserting reset in the middle of a sequence drops all write enables, supply_cut_o and wipe_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_i | input | 1 | Asynchronous tamper request, active high |
| key_we_o | output | 1 | Write enable to the key store |
| key_addr_o | output | KEY_AW (2) | Key store word address |
| key_data_o | output | KEY_W (16) | Key store write data, always zero |
| vec_we_o | output | 1 | Write enable to the vector RAM |
| vec_addr_o | output | VEC_AW (3) | Vector RAM word address |
| vec_data_o | output | VEC_W (8) | Vector RAM write data, always zero |
| supply_cut_o | output | 1 | Request to remove the external memory supply |
| wipe_done_o | output | 1 | Sticky flag: all words have been zeroized |

## Verification
With the defaults, the supply-cut window (12 cycles) is exactly as long as the wipe (4 key words plus 8 vector words). The release of supply_cut_o and the rise of wipe_done_o therefore fall on the same clock edge. The bench triggers the sequence with runs of exactly TRIP cycles and of much longer holds. It records the cycle of the last supply-cut sample and the cycle of the first done sample, and requires them to be adjacent and both to sit at the offsets computed from the trigger edge. The checker also counts the length of the cut window and forbids any write enable while done is high, so an off-by-one on either timer shows up in that shared cycle.

// File: rtl/tz_pkg.sv
package tz_pkg;

  typedef enum logic [1:0] {
    TZ_ARMED = 2'd0,
    TZ_KEYS  = 2'd1,
    TZ_VECS  = 2'd2,
    TZ_DONE  = 2'd3
  } tz_state_e;

  // width needed to index n entries (at least one bit)
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width needed to hold the value n itself
  function automatic int val_width(input int n);
    return $clog2(n + 1) > 0 ? $clog2(n + 1) : 1;
  endfunction

  // trip point placed midway inside the undetermined band
  function automatic int trip_point(input int rej, input int acc);
    return rej + (acc - rej) / 2;
  endfunction

endpackage

// File: rtl/tz_sync.sv
module tz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tz_deglitch.sv
module tz_deglitch #(
  parameter int TRIP_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fire_o
);

  localparam int CW = tz_pkg::val_width(TRIP_CYC);
  localparam logic [CW-1:0] LAST = CW'(TRIP_CYC - 1);

  logic [CW-1:0] run_q;
  logic          at_last;

  assign at_last = (run_q == LAST);

  // run length of consecutive high samples; saturates at TRIP-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!level_i)   run_q <= '0;
    else if (!at_last)   run_q <= run_q + 1'b1;
  end

  assign fire_o = level_i && at_last;

endmodule

// File: rtl/tz_wiper.sv
module tz_wiper #(
  parameter int KEY_WORDS = 4,
  parameter int VEC_WORDS = 8,
  parameter int KEY_AW    = 2,
  parameter int VEC_AW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  output logic              start_o,
  output logic              key_we_o,
  output logic [KEY_AW-1:0] key_addr_o,
  output logic              vec_we_o,
  output logic [VEC_AW-1:0] vec_addr_o,
  output logic              done_o
);

  import tz_pkg::*;

  localparam logic [KEY_AW-1:0] KEY_LAST = KEY_AW'(KEY_WORDS - 1);
  localparam logic [VEC_AW-1:0] VEC_LAST = VEC_AW'(VEC_WORDS - 1);

  tz_state_e         state_q;
  logic [KEY_AW-1:0] key_idx_q;
  logic [VEC_AW-1:0] vec_idx_q;

  assign start_o = (state_q == TZ_ARMED) && fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TZ_ARMED;
      key_idx_q <= '0;
      vec_idx_q <= '0;
    end else begin
      unique case (state_q)
        TZ_ARMED: begin
          if (fire_i) begin
            state_q   <= TZ_KEYS;
            key_idx_q <= '0;
          end
        end
        TZ_KEYS: begin
          if (key_idx_q == KEY_LAST) begin
            state_q   <= TZ_VECS;
            vec_idx_q <= '0;
          end else begin
            key_idx_q <= key_idx_q + 1'b1;
          end
        end
        TZ_VECS: begin
          if (vec_idx_q == VEC_LAST) state_q <= TZ_DONE;
          else                       vec_idx_q <= vec_idx_q + 1'b1;
        end
        default: state_q <= TZ_DONE;
      endcase
    end
  end

  assign key_we_o   = (state_q == TZ_KEYS);
  assign key_addr_o = key_idx_q;
  assign vec_we_o   = (state_q == TZ_VECS);
  assign vec_addr_o = vec_idx_q;
  assign done_o     = (state_q == TZ_DONE);

endmodule

// File: rtl/tz_supply_cut.sv
module tz_supply_cut #(
  parameter int CUT_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic cut_o
);

  localparam int TW = tz_pkg::val_width(CUT_CYC);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start_i)        left_q <= TW'(CUT_CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign cut_o = (left_q != '0);

endmodule

// File: rtl/tamper_zeroize.sv
module tamper_zeroize #(
  parameter int KEY_WORDS  = 4,
  parameter int KEY_W      = 16,
  parameter int VEC_WORDS  = 8,
  parameter int VEC_W      = 8,
  parameter int REJECT_CYC = 6,
  parameter int ACCEPT_CYC = 20,
  parameter int CUT_CYC    = 12,
  parameter int SYNC_STAGES = 2,
  localparam int KEY_AW    = tz_pkg::idx_width(KEY_WORDS),
  localparam int VEC_AW    = tz_pkg::idx_width(VEC_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tamper_i,
  output logic              key_we_o,
  output logic [KEY_AW-1:0] key_addr_o,
  output logic [KEY_W-1:0]  key_data_o,
  output logic              vec_we_o,
  output logic [VEC_AW-1:0] vec_addr_o,
  output logic [VEC_W-1:0]  vec_data_o,
  output logic              supply_cut_o,
  output logic              wipe_done_o
);

  localparam int TRIP_CYC = tz_pkg::trip_point(REJECT_CYC, ACCEPT_CYC);

  initial begin
    if (!(REJECT_CYC < TRIP_CYC && TRIP_CYC <= ACCEPT_CYC && TRIP_CYC >= 2))
      $error("tamper_zeroize: thresholds leave no valid trip point");
  end

  // named internal events, visible to the bound checker
  logic tamper_sync_w;
  logic trip_fire_w;
  logic wipe_start_w;

  tz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (tamper_i),
    .q_o   (tamper_sync_w)
  );

  tz_deglitch #(.TRIP_CYC(TRIP_CYC)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (tamper_sync_w),
    .fire_o  (trip_fire_w)
  );

  tz_wiper #(
    .KEY_WORDS (KEY_WORDS),
    .VEC_WORDS (VEC_WORDS),
    .KEY_AW    (KEY_AW),
    .VEC_AW    (VEC_AW)
  ) u_wipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (trip_fire_w),
    .start_o    (wipe_start_w),
    .key_we_o   (key_we_o),
    .key_addr_o (key_addr_o),
    .vec_we_o   (vec_we_o),
    .vec_addr_o (vec_addr_o),
    .done_o     (wipe_done_o)
  );

  tz_supply_cut #(.CUT_CYC(CUT_CYC)) u_cut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wipe_start_w),
    .cut_o   (supply_cut_o)
  );

  assign key_data_o = '0;
  assign vec_data_o = '0;

endmodule

// File: rtl/tz_checker.sv
module tz_checker #(
  parameter int KEY_W   = 16,
  parameter int VEC_W   = 8,
  parameter int KEY_AW  = 2,
  parameter int VEC_AW  = 3,
  parameter int CUT_CYC = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              key_we,
  input logic [KEY_AW-1:0] key_addr,
  input logic [KEY_W-1:0]  key_data,
  input logic              vec_we,
  input logic [VEC_AW-1:0] vec_addr,
  input logic [VEC_W-1:0]  vec_data,
  input logic              cut,
  input logic              done
);

  localparam int HW = tz_pkg::val_width(CUT_CYC + 1);

  // length of the current supply-cut window, counted independently
  logic [HW-1:0] cut_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cut_len_q <= '0;
    else if (cut) cut_len_q <= cut_len_q + 1'b1;
    else          cut_len_q <= '0;
  end

  // R3: a trip while armed starts the key pass at word 0
  a_r3_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !key_we && !vec_we && !done) |=> (key_we && key_addr == '0));

  // R5: never both ports at once
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_we && vec_we));

  // R5: ascending key addresses
  a_r5_key_step: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && $past(key_we)) |-> (key_addr == $past(key_addr) + 1'b1));

  // R5: ascending vector addresses, first vector word is 0
  a_r5_vec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_we && $past(vec_we)) |-> (vec_addr == $past(vec_addr) + 1'b1));
  a_r5_vec_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_we) |-> (vec_addr == '0 && $past(key_we)));

  // R6: zero data on every write
  a_r6_zero_key: assert property (@(posedge clk) disable iff (!rst_n)
    key_we |-> (key_data == '0));
  a_r6_zero_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |-> (vec_data == '0));

  // R7: cut starts with the first key write and lasts CUT_CYC cycles
  a_r7_cut_with_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_we) |-> $rose(cut));
  a_r7_cut_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cut) |-> (cut_len_q == HW'(CUT_CYC)));
  a_r7_cut_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cut_len_q <= HW'(CUT_CYC));

  // R8: done is sticky and quiet
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!key_we && !vec_we && !cut));

endmodule

bind tamper_zeroize tz_checker #(
  .KEY_W   (KEY_W),
  .VEC_W   (VEC_W),
  .KEY_AW  (KEY_AW),
  .VEC_AW  (VEC_AW),
  .CUT_CYC (CUT_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fire     (trip_fire_w),
  .key_we   (key_we_o),
  .key_addr (key_addr_o),
  .key_data (key_data_o),
  .vec_we   (vec_we_o),
  .vec_addr (vec_addr_o),
  .vec_data (vec_data_o),
  .cut      (supply_cut_o),
  .done     (wipe_done_o)
);

// File: tb/tamper_zeroize_test.sv
`timescale 1ns/1ps
module tamper_zeroize_test;

  localparam int KW = 4, VW = 8, REJ = 6, ACC = 20, CUT = 12;
  // trip point restated: midpoint of the band, rounded down
  localparam int TRIP = (REJ + ACC) / 2;
  localparam int WIPE = KW + VW;

  logic clk = 1'b0, rst_n = 1'b0, tamper = 1'b0;
  logic key_we, vec_we, cut, done;
  logic [1:0]  key_addr;
  logic [15:0] key_data;
  logic [2:0]  vec_addr;
  logic [7:0]  vec_data;

  tamper_zeroize uut (
    .clk(clk), .rst_n(rst_n), .tamper_i(tamper),
    .key_we_o(key_we), .key_addr_o(key_addr), .key_data_o(key_data),
    .vec_we_o(vec_we), .vec_addr_o(vec_addr), .vec_data_o(vec_data),
    .supply_cut_o(cut), .wipe_done_o(done)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor, sampled at the falling edge
  int kw_cnt, vw_cnt, exp_k, exp_v, first_kw, cut_first, cut_last, cut_cnt, done_first;
  bit order_bad, data_bad, overlap, busy_after_done;
  always @(negedge clk) begin
    if (!rst_n) begin
      kw_cnt = 0; vw_cnt = 0; exp_k = 0; exp_v = 0; first_kw = -1;
      cut_first = -1; cut_last = -1; cut_cnt = 0; done_first = -1;
      order_bad = 0; data_bad = 0; overlap = 0; busy_after_done = 0;
    end else begin
      if (key_we) begin
        if (first_kw < 0) first_kw = cyc;
        if (int'(key_addr) != exp_k || vw_cnt != 0) order_bad = 1;
        if (key_data != 0) data_bad = 1;
        exp_k++; kw_cnt++;
      end
      if (vec_we) begin
        if (int'(vec_addr) != exp_v || kw_cnt != KW) order_bad = 1;
        if (vec_data != 0) data_bad = 1;
        exp_v++; vw_cnt++;
      end
      if (key_we && vec_we) overlap = 1;
      if (cut) begin
        if (cut_first < 0) cut_first = cyc;
        cut_last = cyc; cut_cnt++;
      end
      if (done && done_first < 0) done_first = cyc;
      if (done_first >= 0 && (!done || key_we || vec_we || cut)) busy_after_done = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tamper = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // hold tamper high for len samples; returns cycle count at the rise
  task automatic pulse(input int len, output int t_rise);
    @(negedge clk);
    t_rise = cyc; tamper = 1'b1;
    repeat (len) @(negedge clk);
    tamper = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    check(kw_cnt == 0, req, kw_cnt, 0);
    check(vw_cnt == 0 && cut_cnt == 0, req, vw_cnt + cut_cnt, 0);
    check(done_first < 0 && !done, req, done_first, -1);
  endtask

  task automatic expect_full(input int t_rise);
    check(first_kw == t_rise + TRIP + 2, "R3", first_kw, t_rise + TRIP + 2);
    check(kw_cnt == KW && vw_cnt == VW, "R5", kw_cnt * 100 + vw_cnt, KW * 100 + VW);
    check(!order_bad && !overlap, "R5", int'(order_bad) + int'(overlap), 0);
    check(!data_bad, "R6", int'(data_bad), 0);
    check(cut_first == first_kw, "R7", cut_first, first_kw);
    check(cut_cnt == CUT && cut_last == cut_first + CUT - 1, "R7", cut_cnt, CUT);
    check(done_first == first_kw + WIPE, "R8", done_first, first_kw + WIPE);
    check(done_first == cut_last + 1, "R8 shared edge", done_first, cut_last + 1);
    check(!busy_after_done && done, "R8", int'(busy_after_done), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check({key_we, vec_we, cut, done} == 4'b0, "R1", int'({key_we, vec_we, cut, done}), 0);
    check(key_data == 0 && vec_data == 0, "R1", int'(key_data), 0);
  endtask

  task automatic t_short_pulses();
    int t;
    do_reset();
    pulse(REJ, t);   repeat (30) @(negedge clk); expect_idle("R2 reject width");
    pulse(TRIP - 1, t); repeat (30) @(negedge clk); expect_idle("R2 just below trip");
  endtask

  task automatic t_gap_restart();
    int t;
    do_reset();
    pulse(TRIP - 1, t);
    @(negedge clk);                // one low sample
    pulse(TRIP - 1, t);
    repeat (30) @(negedge clk);
    expect_idle("R4");
  endtask

  task automatic t_exact_trip();
    int t;
    do_reset();
    pulse(TRIP, t);               // drops as the wipe begins: R9
    repeat (40) @(negedge clk);
    expect_full(t);
  endtask

  task automatic t_accept_and_repulse();
    int t, t2;
    do_reset();
    pulse(ACC, t);
    repeat (40) @(negedge clk);
    expect_full(t);
    pulse(ACC * 2, t2);            // after done: must not restart (R9)
    repeat (30) @(negedge clk);
    check(kw_cnt == KW && vw_cnt == VW && done, "R9 after done", kw_cnt, KW);
  endtask

  task automatic t_long_hold();
    int t;
    do_reset();
    pulse(100, t);                 // held through and past the sequence
    repeat (20) @(negedge clk);
    expect_full(t);
    check(kw_cnt == KW, "R9 held high", kw_cnt, KW);
  endtask

  task automatic t_reset_mid();
    int t;
    do_reset();
    pulse(TRIP, t);
    repeat (5) @(negedge clk);
    check(vec_we || key_we, "R10 running", int'(key_we | vec_we), 1);
    rst_n = 1'b0;
    #1;
    check({key_we, vec_we, cut, done} == 4'b0, "R10", int'({key_we, vec_we, cut, done}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(done_first < 0 && !cut, "R10 stays armed", done_first, -1);
  endtask

  initial begin
    t_reset_state();
    t_short_pulses();
    t_gap_restart();
    t_exact_trip();
    t_accept_and_repulse();
    t_long_hold();
    t_reset_mid();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule